// File: doc/BRIEF.md
# Serial Port Data Register Stage

This block is the bus-side data stage of a serial receiver/transmitter. A receive shift register hands it complete words, and a transmit shift register takes words from it. Toward the processor there is a single data location: a bus read there returns the held receive word, and a bus write there loads the transmit word.

On the receive side the block keeps one word, a full flag and three error flags (parity, overrun, framing). It raises a receive interrupt while the buffer is full or an error is pending, and it masks the top bit of the word in seven-bit mode. Reading the word clears the full flag. The interrupt stays up after that read if an error is still pending. Errors are cleared only through a separate write-one-to-clear control.

On the transmit side a written word is offered to the transmitter with a valid/ready handshake, and an empty status shows when a new word can be written.

Top module: `sio_data_regs`

## Requirements
- R1: A bus access with `bus_sel`=1 and `bus_wr`=0 is a read and sees the receive word on `bus_rdata`. An access with `bus_sel`=1 and `bus_wr`=1 is a write of `bus_wdata` into the transmit buffer.
- R2: A `rx_load` pulse that is accepted stores `rx_word` and sets `rx_full` to 1 in the following cycle.
- R3: `rx_irq` is 1 exactly when `rx_ie`=1 and either `rx_full` is 1 or an error flag is set.
- R4: A read with no `rx_load` in the same cycle clears `rx_full` to 0 in the next cycle.
- R5: After a read, `rx_irq` falls if no error flag is set, and stays at 1 (with `rx_ie`=1) while any error flag remains set.
- R6: With `rx_len7`=1, bit 7 of `bus_rdata` reads 0 and bits 6..0 hold the stored word. With `rx_len7`=0 all eight bits are returned.
- R7: After reset both buffers are 0x00, `rx_full`, all error flags and `tx_valid` are 0, and `tx_empty` is 1.
- R8: `rx_data_ok` is 1 only while `rx_full` is 1 and no error flag is set.
- R9: A `rx_load` while `rx_full`=1 and no read in the same cycle sets `err_ovr` and keeps the old receive word.
- R10: `err_clr` bit 0 clears `err_par`, bit 1 clears `err_ovr`, bit 2 clears `err_frm`. If a flag is set and cleared in the same cycle, the set wins.
- R11: A write while `tx_empty`=1 raises `tx_valid` with the written byte on `tx_data`. Both hold until a cycle with `tx_ready`=1, after which `tx_empty` returns to 1. A write in that same accepting cycle loads the next byte.
- R12: A write while `tx_valid`=1 and `tx_ready`=0 is ignored: `tx_data` keeps the earlier byte.
- R13: A read and a `rx_load` in the same cycle store the new word, leave `rx_full` at 1 and do not set `err_ovr`.
- R14: An accepted `rx_load` sets `err_par` when `rx_perr`=1 and sets `err_frm` when `rx_ferr`=1. A load dropped by overrun sets neither of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access to the data location this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 8 | Write data for the transmit buffer |
| bus_rdata | output | 8 | Receive word, masked in seven-bit mode |
| rx_ie | input | 1 | Receive interrupt enable |
| rx_len7 | input | 1 | Seven-bit data length mode |
| err_clr | input | 3 | Write-one clear: bit0 parity, bit1 overrun, bit2 framing |
| rx_load | input | 1 | Receive shift register delivers a word |
| rx_word | input | 8 | Delivered word |
| rx_perr | input | 1 | Parity error with the delivered word |
| rx_ferr | input | 1 | Framing error with the delivered word |
| rx_full | output | 1 | Receive buffer holds an unread word |
| rx_irq | output | 1 | Receive interrupt request |
| rx_data_ok | output | 1 | Receive word is full and free of errors |
| err_par | output | 1 | Parity error flag |
| err_ovr | output | 1 | Overrun error flag |
| err_frm | output | 1 | Framing error flag |
| tx_data | output | 8 | Byte offered to the transmitter |
| tx_valid | output | 1 | Transmit byte is waiting |
| tx_ready | input | 1 | Transmitter takes the byte this cycle |
| tx_empty | output | 1 | Transmit buffer can take a write |

## Verification
The bench targets a read that lands in the same cycle as a new word. A design that mishandles this either drops the word, clears the full flag under it, or reports a false overrun. It also loads a word into a full buffer, so a design that overwrites instead of holding the old word, or forgets the overrun flag, shows a wrong read value. Reads are made with errors pending, which exposes an interrupt that is released too early. Writes are made while a transmit byte is still waiting and in the cycle it is accepted, which exposes a byte that is clobbered or a back-to-back write that is lost. Seven-bit mode and error set/clear collisions are checked against an independently computed model.

// File: rtl/sio_pkg.sv
// Package: shared constants for the serial data register stage.
// Assumes: error flag order {framing, overrun, parity} is fixed by the clear control.
package sio_pkg;
    localparam int ERR_N   = 3;
    localparam int ERR_PAR = 0;
    localparam int ERR_OVR = 1;
    localparam int ERR_FRM = 2;
    typedef logic [ERR_N-1:0] sio_err_t;
endpackage

// File: rtl/sio_rx_buf.sv
// Receive buffer: holds one word from the shift register and its full flag.
// Assumes: rd_stb and load are single-cycle strobes; a load arriving with a read is stored.
module sio_rx_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic              load,
    input  logic [DATA_W-1:0] word,
    input  logic              short_mode,
    output logic [DATA_W-1:0] rdata,
    output logic              full,
    output logic              stored,
    output logic              overrun
);
    logic [DATA_W-1:0] buf_q;
    logic              full_q;

    // Decide whether an incoming word fits or collides with an unread one.
    always_comb begin
        stored  = load & (~full_q | rd_stb);
        overrun = load & full_q & ~rd_stb;
    end

    // Capture the word and keep the full flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q  <= '0;
            full_q <= 1'b0;
        end else begin
            if (stored)
                buf_q <= word;
            if (stored)
                full_q <= 1'b1;
            else if (rd_stb)
                full_q <= 1'b0;
        end
    end

    // Mask the top bit in short mode on the read path.
    generate
        if (DATA_W > 1) begin : g_mask
            always_comb begin
                rdata = buf_q;
                if (short_mode)
                    rdata[DATA_W-1] = 1'b0;
            end
        end else begin : g_nomask
            always_comb rdata = short_mode ? 1'b0 : buf_q;
        end
    endgenerate

    assign full = full_q;
endmodule

// File: rtl/sio_err_flags.sv
// Error flags: sticky bits set by events, cleared by a write-one mask.
// Assumes: a set and a clear in one cycle leave the flag set.
module sio_err_flags
    import sio_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  sio_err_t set,
    input  sio_err_t clr,
    output sio_err_t flags
);
    sio_err_t flags_q;

    generate
        for (genvar i = 0; i < ERR_N; i++) begin : g_flag
            // One sticky flag with set priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flags_q[i] <= 1'b0;
                else if (set[i])
                    flags_q[i] <= 1'b1;
                else if (clr[i])
                    flags_q[i] <= 1'b0;
            end
        end
    endgenerate

    assign flags = flags_q;
endmodule

// File: rtl/sio_tx_buf.sv
// Transmit buffer: one word offered to the transmitter with valid/ready.
// Assumes: a write while the buffer is waiting and not being taken is dropped.
module sio_tx_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ready,
    output logic [DATA_W-1:0] data,
    output logic              valid,
    output logic              empty
);
    logic [DATA_W-1:0] data_q;
    logic              valid_q;
    logic              take;
    logic              accept;

    // Handshake and write acceptance.
    always_comb begin
        take   = valid_q & ready;
        accept = wr_stb & (~valid_q | take);
    end

    // Hold the word until the transmitter takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            if (accept)
                data_q <= wdata;
            if (accept)
                valid_q <= 1'b1;
            else if (take)
                valid_q <= 1'b0;
        end
    end

    assign data  = data_q;
    assign valid = valid_q;
    assign empty = ~valid_q;
endmodule

// File: rtl/sio_data_regs.sv
// Top: data location of a serial port. Reads see the receive word, writes feed the transmit word.
// Assumes: one bus access per cycle; the shift registers supply single-cycle load strobes.
module sio_data_regs
    import sio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_ie,
    input  logic              rx_len7,
    input  logic [ERR_N-1:0]  err_clr,
    input  logic              rx_load,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    output logic              rx_full,
    output logic              rx_irq,
    output logic              rx_data_ok,
    output logic              err_par,
    output logic              err_ovr,
    output logic              err_frm,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic              tx_empty
);
    logic     rd_stb;
    logic     wr_stb;
    logic     stored;
    logic     overrun;
    logic     full_w;
    sio_err_t err_set;
    sio_err_t err_q;
    logic     err_any;

    // Split the shared location into read and write strobes.
    always_comb begin
        rd_stb = bus_sel & ~bus_wr;
        wr_stb = bus_sel &  bus_wr;
    end

    sio_rx_buf #(.DATA_W(DATA_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_stb     (rd_stb),
        .load       (rx_load),
        .word       (rx_word),
        .short_mode (rx_len7),
        .rdata      (bus_rdata),
        .full       (full_w),
        .stored     (stored),
        .overrun    (overrun)
    );

    // Error events: line errors only with a stored word, overrun on a collision.
    always_comb begin
        err_set          = '0;
        err_set[ERR_PAR] = stored & rx_perr;
        err_set[ERR_FRM] = stored & rx_ferr;
        err_set[ERR_OVR] = overrun;
    end

    sio_err_flags u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (err_set),
        .clr   (err_clr),
        .flags (err_q)
    );

    sio_tx_buf #(.DATA_W(DATA_W)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_stb(wr_stb),
        .wdata (bus_wdata),
        .ready (tx_ready),
        .data  (tx_data),
        .valid (tx_valid),
        .empty (tx_empty)
    );

    // Status and interrupt; a pending error keeps the request up after a read.
    always_comb begin
        err_any    = |err_q;
        rx_full    = full_w;
        rx_irq     = rx_ie & (full_w | err_any);
        rx_data_ok = full_w & ~err_any;
        err_par    = err_q[ERR_PAR];
        err_ovr    = err_q[ERR_OVR];
        err_frm    = err_q[ERR_FRM];
    end
endmodule

// File: rtl/sio_data_regs_chk.sv
// Checker: properties of the data register stage, bound into the top.
// Assumes: the port names of sio_data_regs and an 8-bit default width.
module sio_data_regs_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              rx_ie,
    input logic              rx_len7,
    input logic [2:0]        err_clr,
    input logic              rx_load,
    input logic              rx_perr,
    input logic              rx_full,
    input logic              rx_irq,
    input logic              rx_data_ok,
    input logic              err_par,
    input logic              err_ovr,
    input logic              err_frm,
    input logic [DATA_W-1:0] tx_data,
    input logic              tx_ready,
    input logic              tx_valid,
    input logic              tx_empty
);
    logic rd;
    logic any_err;
    assign rd      = bus_sel & ~bus_wr;
    assign any_err = err_par | err_ovr | err_frm;

    assert_load_sets_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_load |=> rx_full);
    assert_irq_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ie && rx_full) |-> rx_irq);
    assert_irq_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ie |-> !rx_irq);
    assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !rx_load) |=> !rx_full);
    assert_irq_held_on_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !rx_load && rx_ie && any_err && err_clr == 3'b000) |=> (rx_irq || !rx_ie));
    assert_short_mode_msb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_len7 |-> !bus_rdata[DATA_W-1]);
    assert_invalid_on_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
        any_err |-> !rx_data_ok);
    assert_overrun_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_load && rx_full && !rd) |=> err_ovr);
    assert_parity_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr[0] && !rx_load) |=> !err_par);
    assert_tx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && !tx_empty && $stable(tx_data)));
    assert_tx_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && tx_empty) |=> (tx_valid && tx_data == $past(bus_wdata)));
    assert_same_cycle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_load && rx_full && rd) |=> rx_full);
    assert_parity_capture_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_load && rx_perr && (!rx_full || rd)) |=> err_par);
endmodule

bind sio_data_regs sio_data_regs_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .rx_ie      (rx_ie),
    .rx_len7    (rx_len7),
    .err_clr    (err_clr),
    .rx_load    (rx_load),
    .rx_perr    (rx_perr),
    .rx_full    (rx_full),
    .rx_irq     (rx_irq),
    .rx_data_ok (rx_data_ok),
    .err_par    (err_par),
    .err_ovr    (err_ovr),
    .err_frm    (err_frm),
    .tx_data    (tx_data),
    .tx_ready   (tx_ready),
    .tx_valid   (tx_valid),
    .tx_empty   (tx_empty)
);

// File: tb/sim_sio_data_regs.sv
// Bench: directed corner cases plus seeded random traffic against a bench-side model.
module sim_sio_data_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 0, bus_wr = 0, rx_ie = 0, rx_len7 = 0;
    logic       rx_load = 0, rx_perr = 0, rx_ferr = 0, tx_ready = 0;
    logic [7:0] bus_wdata = 0, rx_word = 0;
    logic [2:0] err_clr = 0;
    logic [7:0] bus_rdata, tx_data;
    logic       rx_full, rx_irq, rx_data_ok, err_par, err_ovr, err_frm, tx_valid, tx_empty;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    logic [7:0] m_rx = 0, m_tx = 0;
    logic       m_full = 0, m_txv = 0;
    logic [2:0] m_err = 0; // {frm, ovr, par}

    always #4 clk = ~clk;

    sio_data_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_ie(rx_ie), .rx_len7(rx_len7),
        .err_clr(err_clr), .rx_load(rx_load), .rx_word(rx_word), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_full(rx_full), .rx_irq(rx_irq), .rx_data_ok(rx_data_ok),
        .err_par(err_par), .err_ovr(err_ovr), .err_frm(err_frm), .tx_data(tx_data),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_empty(tx_empty)
    );

    function automatic logic [7:0] exp_rdata();
        return rx_len7 ? {1'b0, m_rx[6:0]} : m_rx;
    endfunction

    function automatic logic exp_irq();
        return rx_ie & (m_full | (|m_err));
    endfunction

    task automatic chk(input string tag, input string what, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
        end
    endtask

    // Advance the model by one clock with the inputs currently driven.
    task automatic model_step();
        logic rd, wr, stored, ovr, take;
        logic [2:0] set;
        rd = bus_sel & ~bus_wr;
        wr = bus_sel & bus_wr;
        stored = rx_load & (~m_full | rd);
        ovr = rx_load & m_full & ~rd;
        set = {stored & rx_ferr, ovr, stored & rx_perr};
        if (stored) begin m_rx = rx_word; m_full = 1; end
        else if (rd) m_full = 0;
        m_err = (m_err & ~err_clr) | set;
        take = m_txv & tx_ready;
        if (wr && (!m_txv || take)) begin m_tx = bus_wdata; m_txv = 1; end
        else if (take) m_txv = 0;
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "rdata", bus_rdata, exp_rdata());
        chk(tag, "full", {7'd0, rx_full}, {7'd0, m_full});
        chk(tag, "irq", {7'd0, rx_irq}, {7'd0, exp_irq()});
        chk(tag, "errs", {5'd0, err_frm, err_ovr, err_par}, {5'd0, m_err});
        chk(tag, "data_ok", {7'd0, rx_data_ok}, {7'd0, m_full & ~(|m_err)});
        chk(tag, "tx_data", tx_data, m_tx);
        chk(tag, "tx_valid", {6'd0, tx_valid, tx_empty}, {6'd0, m_txv, ~m_txv});
    endtask

    // Drive one cycle of stimulus from a negedge, clock it, and compare at the next negedge.
    task automatic step(input logic sel, input logic wr, input logic [7:0] wd,
                        input logic ld, input logic [7:0] w, input logic pe, input logic fe,
                        input logic [2:0] clr, input logic rdy, input string tag);
        bus_sel = sel; bus_wr = wr; bus_wdata = wd;
        rx_load = ld; rx_word = w; rx_perr = pe; rx_ferr = fe;
        err_clr = clr; tx_ready = rdy;
        @(posedge clk);
        model_step();
        @(negedge clk);
        bus_sel = 0; rx_load = 0; err_clr = 0; tx_ready = 0;
        compare_all(tag);
    endtask

    initial begin
        rx_ie = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R7 reset state
        compare_all("R7");
        chk("R7", "tx_empty", {7'd0, tx_empty}, 8'd1);

        // R2 load, R1 read value, R4 read clears, R3 irq
        step(0, 0, 0, 1, 8'hC5, 0, 0, 0, 0, "R2");
        chk("R3", "irq_full", {7'd0, rx_irq}, 8'd1);
        rx_len7 = 1;
        #1 chk("R6", "short_read", bus_rdata, 8'h45);
        rx_len7 = 0;
        #1 chk("R1", "read_value", bus_rdata, 8'hC5);
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
        chk("R5", "irq_drop", {7'd0, rx_irq}, 8'd0);

        // R9 overrun keeps old word, R14 dropped load sets no line error
        step(0, 0, 0, 1, 8'h11, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 1, 8'h22, 1, 1, 0, 0, "R9");
        chk("R9", "kept_word", bus_rdata, 8'h11);
        chk("R14", "no_par_on_drop", {7'd0, err_par}, 8'd0);
        chk("R8", "invalid", {7'd0, rx_data_ok}, 8'd0);
        // R5 read with error pending keeps irq
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
        chk("R5", "irq_held", {7'd0, rx_irq}, 8'd1);
        // R10 clear overrun; set-wins collision on parity
        step(0, 0, 0, 1, 8'h33, 1, 0, 3'b011, 0, "R10");
        chk("R10", "par_set_wins", {7'd0, err_par}, 8'd1);
        chk("R10", "ovr_cleared", {7'd0, err_ovr}, 8'd0);
        // R13 read with new word same cycle
        step(1, 0, 0, 1, 8'h44, 0, 1, 3'b001, 0, "R13");
        chk("R13", "full_kept", {7'd0, rx_full}, 8'd1);
        chk("R13", "new_word", bus_rdata, 8'h44);
        chk("R14", "frm_set", {7'd0, err_frm}, 8'd1);
        step(1, 0, 0, 0, 0, 0, 0, 3'b111, 0, "R10");

        // R11 tx handshake, R12 write while busy ignored, back-to-back write on accept
        step(1, 1, 8'hA1, 0, 0, 0, 0, 0, 0, "R11");
        step(1, 1, 8'hB2, 0, 0, 0, 0, 0, 0, "R12");
        chk("R12", "tx_kept", tx_data, 8'hA1);
        step(1, 1, 8'hC3, 0, 0, 0, 0, 0, 1, "R11");
        chk("R11", "tx_next", tx_data, 8'hC3);
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R11");
        chk("R11", "tx_empty_after", {7'd0, tx_empty}, 8'd1);

        // seeded random traffic
        void'($urandom(32'd7331));
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom();
            if (i % 64 == 0) rx_len7 = r[20];
            rx_ie = (r[23:21] != 0);
            step(r[2:0] < 2, r[3], 8'($urandom()), r[6:4] == 0, 8'($urandom()),
                 r[9:7] == 0, r[12:10] == 0, (r[15:13] == 0) ? r[18:16] : 3'b000,
                 r[19], "R1");
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule